// File: doc/BRIEF.md
# Serial Stuck-At Fault Campaign Engine

This block grades a set of test vectors against a small combinational circuit that is built into it. The circuit has four primary inputs, ten lines and a two-bit response. Each line can be forced to a constant by a multiplexer that sits on the line. The forcing is controlled by a fault identifier, so the circuit's structure never changes between runs.

Software loads up to sixteen four-bit vectors through a write port and sets the number of vectors to use. It then pulses `start`. The engine first runs the vectors through the unforced circuit and stores each response as the reference. It then visits every fault in ID order, with exactly one line forced per pass. For each fault it replays the vectors and compares every response with the stored reference. The first difference marks the fault as detected and ends that fault's pass at once.

When the last fault has been visited, `done` pulses for one cycle. The per-fault detected bitmap and the detected count then give the coverage of the vector set, as count over total.

Top module: `fault_campaign`

## Requirements
- R1: After reset `busy`, `done`, `detected` and `det_count` are all zero, and `fault_total` reads 20.
- R2: A campaign begins with a reference pass of one cycle per vector, with no line forced. Every reference response is stored before the first fault is injected.
- R3: During each faulty pass exactly one fault is active, and its ID is below 20. Faults are visited in ascending ID order, from 0 to 19.
- R4: A forced line takes its stuck value in place of its computed value, and the forced value propagates to all downstream lines.
- R5: In a faulty pass, vector k is applied in the k-th cycle of that pass. The pass ends in the cycle of the first response that differs from the reference (k+1 cycles). With no difference it ends after all vectors (N cycles).
- R6: Fault ID f forces line f>>1 to the value f[0]. Lines 0..3 are inputs a,b,c,d (vector bits 0..3). Line 4 = a&b, line 5 = c|d, line 6 = ~(l4&l5), line 7 = b^c, line 8 = ~(l7|d), line 9 = l6&l8. The response is {l9,l6}. `detected[f]` reports fault f.
- R7: `done` is high for exactly one cycle, directly after the last fault's pass, with `busy` low in that cycle. `busy` is high from the cycle after the accepted `start` until the last faulty pass ends.
- R8: `det_count` always equals the number of set bits in `detected`. Both are cleared by an accepted `start` and never decrease during a campaign.
- R9: `start` and vector writes are ignored unless the engine is idle (neither busy nor done).
- R10: `num_vecs` is sampled at `start`, and values above 16 count as 16. With 0 vectors, the reference pass and each faulty pass take one cycle, and no fault is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Vector write strobe |
| wr_addr | input | 4 | Vector slot to write |
| wr_data | input | 4 | Vector value (bit i drives input line i) |
| num_vecs | input | 5 | Vectors per pass, sampled at start |
| start | input | 1 | Begin a campaign |
| busy | output | 1 | Reference or faulty pass in progress |
| done | output | 1 | One-cycle end-of-campaign pulse |
| detected | output | 20 | Per-fault detected flags, indexed by fault ID |
| det_count | output | 5 | Number of detected faults |
| fault_total | output | 5 | Size of the fault list (20) |

## Verification
On every cycle the assertions check the following: injection is off until the reference pass has finished, and the active fault ID is in range. The vector index stays below the count. A detection restarts the vector index. `done` is a lone pulse with `busy` low. The count matches the bitmap's population and never exceeds the list size.

Other properties show only in the bench's scenarios, where a behavioural model predicts the busy/done timeline every clock:
- whether each fault is truly detected through the forcing multiplexers;
- that the pass length shrinks to the first mismatching vector;
- the clamping and zero-vector cases;
- the ignoring of `start` and writes during a run.

// File: rtl/fcamp_pkg.sv
package fcamp_pkg;
  localparam int NUM_IN     = 4;
  localparam int NUM_LINES  = 10;
  localparam int NUM_FAULTS = 2 * NUM_LINES;
  localparam int FID_W      = $clog2(NUM_FAULTS);
  localparam int LINE_W     = FID_W - 1;
  localparam int CNT_W      = $clog2(NUM_FAULTS + 1);
  localparam int RESP_W     = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GOLD  = 2'd1,
    ST_FAULT = 2'd2,
    ST_DONE  = 2'd3
  } camp_state_t;
endpackage

// File: rtl/fcamp_cut.sv
module fcamp_cut
  import fcamp_pkg::*;
(
  input  logic [NUM_IN-1:0] vec,
  input  logic              inj_en,
  input  logic [FID_W-1:0]  inj_id,
  output logic [RESP_W-1:0] resp
);
  logic [LINE_W-1:0]    line_id;
  logic                 stuck_val;
  logic [NUM_LINES-1:0] force_sel;
  logic [NUM_LINES-1:0] net;

  assign line_id   = inj_id[FID_W-1:1];
  assign stuck_val = inj_id[0];

  // one select variable per line; at most one is set at a time
  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : g_sel
      assign force_sel[g] = inj_en && (line_id == LINE_W'(g));
    end
  endgenerate

  // evaluate lines in topological order; each passes through its mux
  always_comb begin
    logic [NUM_LINES-1:0] v;
    v = '0;
    v[0] = force_sel[0] ? stuck_val : vec[0];
    v[1] = force_sel[1] ? stuck_val : vec[1];
    v[2] = force_sel[2] ? stuck_val : vec[2];
    v[3] = force_sel[3] ? stuck_val : vec[3];
    v[4] = force_sel[4] ? stuck_val : (v[0] & v[1]);
    v[5] = force_sel[5] ? stuck_val : (v[2] | v[3]);
    v[6] = force_sel[6] ? stuck_val : ~(v[4] & v[5]);
    v[7] = force_sel[7] ? stuck_val : (v[1] ^ v[2]);
    v[8] = force_sel[8] ? stuck_val : ~(v[7] | v[3]);
    v[9] = force_sel[9] ? stuck_val : (v[6] & v[8]);
    net = v;
  end

  assign resp = {net[9], net[6]};
endmodule

// File: rtl/fcamp_store.sv
module fcamp_store
  import fcamp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vwe,
  input  logic [AW-1:0]     vwaddr,
  input  logic [NUM_IN-1:0] vwdata,
  input  logic              rwe,
  input  logic [AW-1:0]     idx,
  input  logic [RESP_W-1:0] rwdata,
  output logic [NUM_IN-1:0] vec_out,
  output logic [RESP_W-1:0] ref_out
);
  logic [NUM_IN-1:0] vmem [DEPTH];
  logic [RESP_W-1:0] rmem [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      logic v_en, r_en;
      assign v_en = vwe && (vwaddr == AW'(g));
      assign r_en = rwe && (idx == AW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vmem[g] <= '0;
          rmem[g] <= '0;
        end else begin
          if (v_en) vmem[g] <= vwdata;
          if (r_en) rmem[g] <= rwdata;
        end
      end
    end
  endgenerate

  assign vec_out = vmem[idx];
  assign ref_out = rmem[idx];
endmodule

// File: rtl/fcamp_ctrl.sv
module fcamp_ctrl
  import fcamp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int NV_W = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NV_W-1:0]   num_vecs,
  input  logic [RESP_W-1:0] resp,
  input  logic [RESP_W-1:0] ref_in,
  output logic              idle,
  output logic              busy,
  output logic              done,
  output logic              clear,
  output logic [AW-1:0]     vidx,
  output logic              inj_en,
  output logic [FID_W-1:0]  inj_id,
  output logic              ref_we,
  output logic              det_set
);
  camp_state_t      state_q, state_d;
  logic [AW-1:0]    vidx_q, vidx_d;
  logic [FID_W-1:0] fid_q, fid_d;
  logic [NV_W-1:0]  cnt_q, cnt_d, cnt_clamp;
  logic             en, last_vec, empty, mism;

  assign cnt_clamp = (num_vecs > NV_W'(DEPTH)) ? NV_W'(DEPTH) : num_vecs;
  assign empty     = (cnt_q == '0);
  assign last_vec  = ({1'b0, vidx_q} == (cnt_q - NV_W'(1)));
  assign mism      = (state_q == ST_FAULT) && !empty && (resp != ref_in);

  always_comb begin
    state_d = state_q;
    vidx_d  = vidx_q;
    fid_d   = fid_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_GOLD;
        vidx_d  = '0;
        fid_d   = '0;
        cnt_d   = cnt_clamp;
      end
      ST_GOLD: begin
        if (empty || last_vec) begin
          state_d = ST_FAULT;
          vidx_d  = '0;
        end else begin
          vidx_d = vidx_q + AW'(1);
        end
      end
      ST_FAULT: begin
        if (mism || empty || last_vec) begin
          vidx_d = '0;
          if (fid_q == FID_W'(NUM_FAULTS - 1)) state_d = ST_DONE;
          else                                 fid_d   = fid_q + FID_W'(1);
        end else begin
          vidx_d = vidx_q + AW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign en = (state_q != ST_IDLE) || start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vidx_q  <= '0;
      fid_q   <= '0;
      cnt_q   <= '0;
    end else if (en) begin
      state_q <= state_d;
      vidx_q  <= vidx_d;
      fid_q   <= fid_d;
      cnt_q   <= cnt_d;
    end
  end

  assign idle    = (state_q == ST_IDLE);
  assign busy    = (state_q == ST_GOLD) || (state_q == ST_FAULT);
  assign done    = (state_q == ST_DONE);
  assign clear   = idle && start;
  assign vidx    = vidx_q;
  assign inj_en  = (state_q == ST_FAULT);
  assign inj_id  = fid_q;
  assign ref_we  = (state_q == ST_GOLD) && !empty;
  assign det_set = mism;

  // first injected cycle must follow the last reference cycle
  assert_gold_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inj_en) |-> ($past(ref_we) || $past(empty)));
  assert_fid_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inj_en |-> (inj_id < FID_W'(NUM_FAULTS)));
  assert_abort_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    det_set |=> (vidx_q == '0));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  assert_vidx_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !empty) |-> ({1'b0, vidx_q} < cnt_q));
endmodule

// File: rtl/fault_campaign.sv
module fault_campaign
  import fcamp_pkg::*;
#(
  parameter int VEC_DEPTH = 16,
  localparam int AW   = $clog2(VEC_DEPTH),
  localparam int NV_W = AW + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [NUM_IN-1:0]     wr_data,
  input  logic [NV_W-1:0]       num_vecs,
  input  logic                  start,
  output logic                  busy,
  output logic                  done,
  output logic [NUM_FAULTS-1:0] detected,
  output logic [CNT_W-1:0]      det_count,
  output logic [CNT_W-1:0]      fault_total
);
  logic rst_meta, rst_i;
  logic idle, clear, inj_en, ref_we, det_set;
  logic [AW-1:0]     vidx;
  logic [FID_W-1:0]  inj_id;
  logic [NUM_IN-1:0] vec;
  logic [RESP_W-1:0] resp, ref_r;
  logic [NUM_FAULTS-1:0] det_q, det_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  st_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  fcamp_ctrl #(.DEPTH(VEC_DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_i), .start(start), .num_vecs(num_vecs),
    .resp(resp), .ref_in(ref_r), .idle(idle), .busy(busy), .done(done),
    .clear(clear), .vidx(vidx), .inj_en(inj_en), .inj_id(inj_id),
    .ref_we(ref_we), .det_set(det_set)
  );

  fcamp_store #(.DEPTH(VEC_DEPTH)) u_store (
    .clk(clk), .rst_n(rst_i), .vwe(wr_en && idle), .vwaddr(wr_addr),
    .vwdata(wr_data), .rwe(ref_we), .idx(vidx), .rwdata(resp),
    .vec_out(vec), .ref_out(ref_r)
  );

  fcamp_cut u_cut (.vec(vec), .inj_en(inj_en), .inj_id(inj_id), .resp(resp));

  always_comb begin
    det_d = det_q;
    cnt_d = cnt_q;
    if (clear) begin
      det_d = '0;
      cnt_d = '0;
    end else if (det_set) begin
      det_d[inj_id] = 1'b1;
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  assign st_en = clear || det_set;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      det_q <= '0;
      cnt_q <= '0;
    end else if (st_en) begin
      det_q <= det_d;
      cnt_q <= cnt_d;
    end
  end

  assign detected    = det_q;
  assign det_count   = cnt_q;
  assign fault_total = CNT_W'(NUM_FAULTS);

  assert_count_match_R8: assert property (@(posedge clk) disable iff (!rst_i)
    det_count == CNT_W'($countones(detected)));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_i)
    det_count <= CNT_W'(NUM_FAULTS));
  assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_i)
    busy |=> ((detected & $past(detected)) == $past(detected)));
endmodule

// File: tb/fault_campaign_bench.sv
module fault_campaign_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic [4:0] num_vecs = '0;
  logic start = 1'b0;
  logic busy, done;
  logic [19:0] detected;
  logic [4:0] det_count, fault_total;

  int total = 0;
  int bad = 0;
  int mem [16];
  bit finished = 0;

  always #2ns clk = ~clk;

  fault_campaign u_fault_campaign (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .num_vecs(num_vecs), .start(start), .busy(busy),
    .done(done), .detected(detected), .det_count(det_count),
    .fault_total(fault_total)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural model of the circuit, as stated in R6
  function automatic int model(input int v, input bit en, input int fid);
    int l [10];
    int ln, sv;
    ln = fid / 2;
    sv = fid % 2;
    for (int i = 0; i < 10; i++) begin
      case (i)
        0, 1, 2, 3: l[i] = (v >> i) & 1;
        4: l[i] = l[0] & l[1];
        5: l[i] = l[2] | l[3];
        6: l[i] = 1 - (l[4] & l[5]);
        7: l[i] = l[1] ^ l[2];
        8: l[i] = 1 - (l[7] | l[3]);
        default: l[i] = l[6] & l[8];
      endcase
      if (en && ln == i) l[i] = sv;
    end
    return l[9] * 2 + l[6];
  endfunction

  task automatic write_vec(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 4'(d);
    mem[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int nv, input bit poke, input string tag);
    int n, len, cnt;
    int exp_det [20];
    bit q_busy [$];
    bit q_done [$];
    n = (nv > 16) ? 16 : nv;
    cnt = 0;
    for (int i = 0; i < (n == 0 ? 1 : n); i++) begin q_busy.push_back(1); q_done.push_back(0); end
    for (int f = 0; f < 20; f++) begin
      exp_det[f] = 0;
      len = (n == 0) ? 1 : n;
      for (int k = 0; k < n; k++)
        if (model(mem[k], 1, f) != model(mem[k], 0, 0)) begin
          exp_det[f] = 1; len = k + 1; break;
        end
      cnt += exp_det[f];
      for (int i = 0; i < len; i++) begin q_busy.push_back(1); q_done.push_back(0); end
    end
    q_busy.push_back(0); q_done.push_back(1);
    q_busy.push_back(0); q_done.push_back(0);
    @(negedge clk);
    num_vecs = 5'(nv);
    start = 1'b1;
    for (int c = 0; c < q_busy.size(); c++) begin
      @(negedge clk);
      start = 1'b0;
      wr_en = 1'b0;
      if (poke && c == 2) begin
        // R9: start and a vector write during a run must be ignored
        start = 1'b1; wr_en = 1'b1; wr_addr = 4'd0; wr_data = 4'(~mem[0]);
      end
      if (busy !== q_busy[c] || done !== q_done[c]) begin
        chk({"R5/R7 timeline ", tag}, {busy, done}, {q_busy[c], q_done[c]});
        break;
      end
    end
    chk({"R7 timeline ", tag}, 1, 1);
    for (int f = 0; f < 20; f++)
      chk({"R3/R4/R6 detected ", tag}, detected[f], exp_det[f]);
    chk({"R8 count ", tag}, det_count, cnt);
  endtask

  initial begin
    #400us;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 detected", detected, 0);
    chk("R1 count", det_count, 0);
    chk("R1 total", fault_total, 20);
    // exhaustive vector set (R2 R4 R5 R6)
    for (int i = 0; i < 16; i++) write_vec(i, i);
    run(16, 0, "full");
    // R6: line 9 stuck-at-0 (id 18) is caught by the full set
    chk("R6 id18", detected[18], 1);
    // short set, early abort shape differs (R5 R10)
    run(3, 0, "three");
    // zero vectors (R10)
    run(0, 0, "zero");
    chk("R10 zero count", det_count, 0);
    // clamped count with ignored start/write during the run (R9 R10)
    run(31, 1, "clamp");
    // rerun proves vector 0 was not overwritten (R9)
    run(16, 0, "after_poke");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule